// File: doc/BRIEF.md
# PLL Lock-Loss Status Flag

This block keeps a sticky record of whether a phase-locked loop has dropped out of lock. A phase comparator drives two active-low request lines, one that asks the loop to speed up and one that asks it to slow down. While the loop is out of lock, one of these lines sits low. Both lines are brought into the system clock domain through a chain of synchronising flip-flops. The synchronised levels are then looked at only on a one-cycle tick that marks each period of the reference frequency currently in use. If either line is low on a tick, the flag is set, and it stays set until software reads it.

Software sees the flag in the lowest bit of an 8-bit read-only status word, and the other bits read as zero. A read strobe both presents the word and clears the flag at the end of that cycle. Because clearing happens on the read, software must poll at intervals longer than one reference period, so that every period with an unlock gets a chance to set the flag between two reads. If a tick that sets the flag lands in the same cycle as a clearing read, the set is kept, so the event shows up on the next read.

Top module: `lock_loss_flag`

## Requirements
- R1: While reset is asserted, and after it is released, rd_data reads 8'h00 until a set occurs.
- R2: A clock cycle with ref_tick high and the synchronised up_req_n low sets the flag, and rd_data[0] reads 1 after that rising edge.
- R3: A clock cycle with ref_tick high and the synchronised dn_req_n low sets the flag in the same way as R2.
- R4: Request lines that are low have no effect in a cycle where ref_tick is low: the flag keeps its value.
- R5: The flag is sticky. A tick with both request lines high leaves a set flag at 1.
- R6: A cycle with rd_stb high clears the flag at that rising edge, unless R7 applies.
- R7: If a setting tick and rd_stb fall in the same cycle, the flag is 1 after that edge.
- R8: rd_data[7:1] always reads zero, and the flag appears only in bit 0.
- R9: Each request line passes through two flip-flops. A level applied before rising edge e1 is first seen by a tick in the cycle that ends at edge e3. A tick in the cycle that ends at edge e2 still sees the old level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ref_tick | input | 1 | One-cycle pulse once per reference-frequency period |
| up_req_n | input | 1 | Active-low up request from the phase comparator (asynchronous) |
| dn_req_n | input | 1 | Active-low down request from the phase comparator (asynchronous) |
| rd_stb | input | 1 | Status read strobe. Clears the flag at the end of the cycle |
| rd_data | output | 8 | Status word: bit 0 is the lock-loss flag, bits 7:1 are zero |

## Verification
Two functions can land in the same cycle: a setting tick, and the clearing effect of a status read. The bench makes them meet in several ways. It drives ref_tick and rd_stb together on purpose while a request line is low. It also lets random tick and strobe patterns coincide while the request levels are held steady. The expected flag is computed in the bench with the set taking priority over the clear. After every edge, the full 8-bit read word is compared against that expectation, so a design that lets the clear win, or that drops the event, shows up as a mismatch on bit 0.

// File: rtl/lock_loss_pkg.sv
package lock_loss_pkg;
  localparam int unsigned STATUS_W    = 8;
  localparam int unsigned FLAG_POS    = 0;
  localparam int unsigned SYNC_DEPTH  = 2;
  localparam int unsigned RST_DEPTH   = 2;

  typedef logic [STATUS_W-1:0] status_word_t;

  typedef struct packed {
    logic up_n;
    logic dn_n;
  } req_pair_t;
endpackage

// File: rtl/lock_loss_rst_sync.sv
module lock_loss_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [DEPTH-1:0] rst_q;
  logic [DEPTH-1:0] rst_d;

  always_comb begin
    rst_d = {rst_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_q <= '0;
    else         rst_q <= rst_d;
  end

  assign srst_n = rst_q[DEPTH-1];
endmodule

// File: rtl/lock_loss_sync.sv
module lock_loss_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] stage_q;
      logic [STAGES-1:0] stage_d;

      always_comb begin
        stage_d = {stage_q[STAGES-2:0], din[g]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '1;
        else        stage_q <= stage_d;
      end

      assign dout[g] = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/lock_loss_tracker.sv
module lock_loss_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic up_s_n,
  input  logic dn_s_n,
  input  logic clr,
  output logic flag
);
  logic flag_q;
  logic flag_d;
  logic unlock_seen;

  assign unlock_seen = tick & (~up_s_n | ~dn_s_n);

  always_comb begin
    flag_d = flag_q;
    if (unlock_seen)  flag_d = 1'b1;
    else if (clr)     flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R2 R3 R7
  set_on_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(up_s_n && dn_s_n)) |=> flag_q);

  // R4
  no_set_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !tick) |=> !flag_q);

  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  // R6
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !tick) |=> !flag_q);
endmodule

// File: rtl/lock_loss_readport.sv
module lock_loss_readport #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned POS   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flag,
  output logic [WIDTH-1:0] word
);
  always_comb begin
    word      = '0;
    word[POS] = flag;
  end

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(word) <= 1 && word[POS] == flag);
endmodule

// File: rtl/lock_loss_flag.sv
module lock_loss_flag
  import lock_loss_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_tick,
  input  logic                up_req_n,
  input  logic                dn_req_n,
  input  logic                rd_stb,
  output logic [STATUS_W-1:0] rd_data
);
  logic      srst_n;
  req_pair_t req_raw;
  req_pair_t req_sync;
  logic      flag;

  assign req_raw.up_n = up_req_n;
  assign req_raw.dn_n = dn_req_n;

  lock_loss_rst_sync #(.DEPTH(RST_DEPTH)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  lock_loss_sync #(.WIDTH(2), .STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .din   (req_raw),
    .dout  (req_sync)
  );

  lock_loss_tracker u_track (
    .clk    (clk),
    .rst_n  (srst_n),
    .tick   (ref_tick),
    .up_s_n (req_sync.up_n),
    .dn_s_n (req_sync.dn_n),
    .clr    (rd_stb),
    .flag   (flag)
  );

  lock_loss_readport #(.WIDTH(STATUS_W), .POS(FLAG_POS)) u_rd (
    .clk   (clk),
    .rst_n (srst_n),
    .flag  (flag),
    .word  (rd_data)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> rd_data == '0);
endmodule

// File: tb/lock_loss_flag_bench.sv
module lock_loss_flag_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_tick;
  logic       up_req_n;
  logic       dn_req_n;
  logic       rd_stb;
  logic [7:0] rd_data;

  int compared   = 0;
  int mismatched = 0;
  int cycles     = 0;
  bit exp_flag;
  bit done = 0;

  always #10 clk = ~clk;

  lock_loss_flag u_lock_loss_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .up_req_n (up_req_n),
    .dn_req_n (dn_req_n),
    .rd_stb   (rd_stb),
    .rd_data  (rd_data)
  );

  function automatic bit next_flag(bit cur, bit t, bit r, bit up_n, bit dn_n);
    if (t && (!up_n || !dn_n)) return 1'b1;
    if (r) return 1'b0;
    return cur;
  endfunction

  function automatic logic [7:0] word_of(bit f);
    return {7'b0, f};
  endfunction

  task automatic check(input string tag, input logic [7:0] exp);
    compared++;
    if (rd_data !== exp) begin
      mismatched++;
      $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, exp);
    end
  endtask

  // Drives at a falling edge, model updates at the rising edge, checks at the next falling edge.
  // Request levels must have been stable for at least two prior edges.
  task automatic step(input bit t, input bit r, input string tag);
    ref_tick = t;
    rd_stb   = r;
    @(posedge clk);
    exp_flag = next_flag(exp_flag, t, r, up_req_n, dn_req_n);
    @(negedge clk);
    check(tag, word_of(exp_flag));
    ref_tick = 1'b0;
    rd_stb   = 1'b0;
  endtask

  task automatic settle(input bit u, input bit d);
    up_req_n = u;
    dn_req_n = d;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R4 settle");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: run exceeded cycle limit");
      finish_run();
    end
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    rst_n = 1'b0; ref_tick = 1'b0; rd_stb = 1'b0;
    up_req_n = 1'b1; dn_req_n = 1'b1; exp_flag = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", 8'h00);

    // R4: low request without tick has no effect
    settle(1'b0, 1'b1);
    step(1'b0, 1'b0, "R4 no tick");
    // R2: up request sets
    step(1'b1, 1'b0, "R2 up sets");
    // R5: sticky with lines high
    settle(1'b1, 1'b1);
    step(1'b1, 1'b0, "R5 sticky");
    check("R8 upper bits", 8'h01);
    // R6: read clears
    step(1'b0, 1'b1, "R6 read clears");
    // R3: down request sets
    settle(1'b1, 1'b0);
    step(1'b1, 1'b0, "R3 down sets");
    // R7: set and read together, set wins
    step(1'b1, 1'b1, "R7 set beats clear");
    settle(1'b1, 1'b1);
    step(1'b0, 1'b1, "R6 clear after R7");

    // R9: synchroniser latency
    up_req_n = 1'b0;
    @(posedge clk);           // e1
    @(negedge clk);
    ref_tick = 1'b1;
    @(posedge clk);           // e2: old level still seen
    @(negedge clk);
    check("R9 tick at e2 ignored", 8'h00);
    @(posedge clk);           // e3: new level seen
    @(negedge clk);
    ref_tick = 1'b0;
    exp_flag = 1'b1;
    check("R9 tick at e3 sets", 8'h01);
    settle(1'b1, 1'b1);
    step(1'b0, 1'b1, "R6 clear");

    // Random phase
    for (int k = 0; k < 400; k++) begin
      bit u = ($urandom % 3) != 0;
      bit d = ($urandom % 3) != 0;
      settle(u, d);
      for (int j = 0; j < 6; j++)
        step(($urandom % 2) == 1, ($urandom % 3) == 0, "R2 R3 R5 R6 R7 random");
    end

    finish_run();
  end
endmodule